// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor that completes one instruction per clock. It has a program counter, a 32 x 32-bit register file and two private word memories of 256 entries each: one for instructions and one for data. Each cycle it fetches the word the program counter points at, decodes it, reads two registers, computes through a three-function ALU and commits its results on the next rising edge. The supported operations are wrap-around add, wrap-around subtract, OR with an immediate, word load, word store and branch on equality. Any other encoding only advances the program counter.

A host fills both memories through a loader port, normally while the core is held in reset. It then releases reset and watches progress on the program-counter output. It reads architectural registers through a combinational debug read port. Memory addresses are byte addresses. Only bits [9:2] select a word, so the two low bits and the bits above bit 9 are ignored.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and every register reads 0; the first instruction fetched after release is the one at word 0.
- R2: Register-format word (opcode bits 31:26 = 0x00, rs 25:21, rt 20:16, rd 15:11, function 5:0) with function 0x21 writes rs + rt modulo 2^32 into rd and advances pc by 4.
- R3: Register-format function 0x23 writes rs - rt modulo 2^32 into rd and advances pc by 4.
- R4: Opcode 0x0D writes rs OR the zero-extended immediate (bits 15:0) into rt.
- R5: Opcode 0x23 writes into rt the data word at byte address rs + sign-extended immediate, with word index taken from address bits [9:2].
- R6: Opcode 0x2B stores rt into the data word at byte address rs + sign-extended immediate; a later load from that address returns it.
- R7: Opcode 0x04 sets the next pc to pc + 4 + (sign-extended immediate << 2) when rs equals rt, including negative offsets, and to pc + 4 otherwise; it writes no register.
- R8: Register 0 always reads 0; writes aimed at it are dropped.
- R9: An unlisted opcode, or opcode 0x00 with a function code other than 0x21 or 0x23, changes no register and no memory and advances pc by 4.
- R10: A register written by an instruction is visible on the debug read port, and to the next instruction, in the following cycle.
- R11: A loader write with load_en_i high stores load_data_i at word load_addr_i of the instruction memory when load_sel_i is 0 and of the data memory when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_en_i | input | 1 | Loader write strobe |
| load_sel_i | input | 1 | Loader target: 0 instruction memory, 1 data memory |
| load_addr_i | input | 8 | Loader word index |
| load_data_i | input | 32 | Loader write data |
| dbg_raddr_i | input | 5 | Debug register read index |
| dbg_rdata_o | output | 32 | Debug register read data (combinational) |
| pc_o | output | 32 | Current program counter |

## Verification
The program counter moves one instruction per rising edge. The pc_o value seen just after a falling edge therefore belongs to the instruction executing in that cycle. A register result becomes readable one edge after its instruction, so it is checked in the step of the following instruction. A store becomes visible only through a later load, and that load's register is checked one step after the load. The driver queues one expected step per cycle, holding a pc and optionally a register. The monitor pops one step at each falling edge and compares it after the combinational debug path has settled, so every comparison falls exactly in the cycle where the result is due.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    sext;
    logic    mem_we;
    logic    mem_to_reg;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW    = 32,
  parameter int NREGS = 32,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] ra_i,
  output logic [DW-1:0] ra_o,
  input  logic [RW-1:0] rb_i,
  output logic [DW-1:0] rb_o,
  input  logic [RW-1:0] rc_i,
  output logic [DW-1:0] rc_o
);
  logic [DW-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // index 0 is hard zero
  assign ra_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign rb_o = (rb_i == '0) ? '0 : regs_q[rb_i];
  assign rc_o = (rc_i == '0) ? '0 : regs_q[rc_i];
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (op_i)
      OP_RTYPE: begin
        if (funct_i == FN_ADDU || funct_i == FN_SUBU) begin
          ctrl_o.reg_we = 1'b1;
          ctrl_o.dst_rd = 1'b1;
          ctrl_o.alu_op = (funct_i == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.src_imm    = 1'b1;
        ctrl_o.sext       = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.sext   = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_OR:  res_o = a_i | b_i;
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int DW        = 32,
  parameter int NREGS     = 32,
  parameter int MEM_WORDS = 256,
  localparam int AW       = $clog2(MEM_WORDS),
  localparam int RW       = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_en_i,
  input  logic          load_sel_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic [RW-1:0] dbg_raddr_i,
  output logic [DW-1:0] dbg_rdata_o,
  output logic [DW-1:0] pc_o
);
  logic [DW-1:0] pc_q, pc_next, pc_plus4, br_target;
  logic [DW-1:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_res, dmem_rdata, wb_data;
  logic [5:0]    op, funct;
  logic [RW-1:0] rs_addr, rt_addr, rd_addr, wr_addr;
  logic [15:0]   imm;
  logic          alu_zero, reg_we, mem_we, br_taken;
  ctrl_t         ctrl;

  sc_mem #(.DW(DW), .DEPTH(MEM_WORDS)) u_imem (
    .clk_i   (clk_i),
    .we_i    (load_en_i && !load_sel_i),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (pc_q[AW+1:2]),
    .rdata_o (instr)
  );

  assign op      = instr[31:26];
  assign rs_addr = instr[21+:RW];
  assign rt_addr = instr[16+:RW];
  assign rd_addr = instr[11+:RW];
  assign funct   = instr[5:0];
  assign imm     = instr[15:0];

  sc_decode u_dec (.op_i(op), .funct_i(funct), .ctrl_o(ctrl));

  // core writes are held off in reset and while the loader owns the port
  assign reg_we  = ctrl.reg_we && rst_ni;
  assign mem_we  = ctrl.mem_we && rst_ni && !load_en_i;
  assign wr_addr = ctrl.dst_rd ? rd_addr : rt_addr;

  sc_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .waddr_i (wr_addr),
    .wdata_i (wb_data),
    .ra_i    (rs_addr),
    .ra_o    (rs_val),
    .rb_i    (rt_addr),
    .rb_o    (rt_val),
    .rc_i    (dbg_raddr_i),
    .rc_o    (dbg_rdata_o)
  );

  assign imm_ext = ctrl.sext ? {{(DW-16){imm[15]}}, imm} : {{(DW-16){1'b0}}, imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.DW(DW)) u_alu (
    .op_i   (ctrl.alu_op),
    .a_i    (rs_val),
    .b_i    (alu_b),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  sc_mem #(.DW(DW), .DEPTH(MEM_WORDS)) u_dmem (
    .clk_i   (clk_i),
    .we_i    ((load_en_i && load_sel_i) || mem_we),
    .waddr_i (load_en_i ? load_addr_i : alu_res[AW+1:2]),
    .wdata_i (load_en_i ? load_data_i : rt_val),
    .raddr_i (alu_res[AW+1:2]),
    .rdata_o (dmem_rdata)
  );

  assign wb_data   = ctrl.mem_to_reg ? dmem_rdata : alu_res;
  assign pc_plus4  = pc_q + DW'(4);
  assign br_target = pc_plus4 + {imm_ext[DW-3:0], 2'b00};
  assign br_taken  = ctrl.branch && alu_zero;
  assign pc_next   = br_taken ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic [31:0] instr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic [4:0]  rs_addr_i,
  input logic        reg_we_i,
  input logic        mem_we_i
);
  logic [5:0]  op;
  logic [5:0]  fn;
  logic        known;
  logic [31:0] offs;

  assign op    = instr_i[31:26];
  assign fn    = instr_i[5:0];
  assign known = (op == 6'h00 && (fn == 6'h21 || fn == 6'h23)) || op == 6'h0D ||
                 op == 6'h23 || op == 6'h2B || op == 6'h04;
  assign offs  = {{14{instr_i[15]}}, instr_i[15:0], 2'b00};

  // R1
  pc_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00);

  // R9
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'h04) |=> pc_i == $past(pc_i) + 32'd4);

  // R7
  branch_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'h04 && rs_val_i == rt_val_i) |=> pc_i == $past(pc_i) + 32'd4 + $past(offs));

  // R7
  branch_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'h04 && rs_val_i != rt_val_i) |=> pc_i == $past(pc_i) + 32'd4);

  // R8
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_addr_i == 5'd0) |-> rs_val_i == 32'd0);

  // R9
  unknown_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> !reg_we_i && !mem_we_i);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_i      (pc_o),
  .instr_i   (instr),
  .rs_val_i  (rs_val),
  .rt_val_i  (rt_val),
  .rs_addr_i (rs_addr),
  .reg_we_i  (reg_we),
  .mem_we_i  (mem_we)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en_i = 1'b0;
  logic        load_sel_i = 1'b0;
  logic [7:0]  load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [4:0]  dbg_raddr_i = '0;
  logic [31:0] dbg_rdata_o;
  logic [31:0] pc_o;

  int total = 0;
  int bad = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] pc;
    bit          has_reg;
    logic [4:0]  r;
    logic [31:0] v;
  } step_t;

  step_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_core uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en_i),
    .load_sel_i  (load_sel_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .dbg_raddr_i (dbg_raddr_i),
    .dbg_rdata_o (dbg_rdata_o),
    .pc_o        (pc_o)
  );

  function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic load(bit sel, int idx, logic [31:0] data);
    load_en_i   = 1'b1;
    load_sel_i  = sel;
    load_addr_i = 8'(idx);
    load_data_i = data;
    @(negedge clk_i);
  endtask

  task automatic push(string tag, logic [31:0] pc, bit has_reg = 0, int r = 0, logic [31:0] v = 0);
    step_t s;
    s.tag = tag; s.pc = pc; s.has_reg = has_reg; s.r = 5'(r); s.v = v;
    sb_q.push_back(s);
  endtask

  // monitor: one step per cycle, sampled just after the falling edge
  initial begin
    wait (run);
    while (sb_q.size() != 0) begin
      step_t s;
      s = sb_q.pop_front();
      if (s.has_reg) dbg_raddr_i = s.r;
      #1;
      check({s.tag, " pc"}, pc_o, s.pc);
      if (s.has_reg) check({s.tag, " reg"}, dbg_rdata_o, s.v);
      @(negedge clk_i);
    end
    done = 1'b1;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R11: program into instruction memory, data into data memory
    load(0,  0, itype(6'h0D, 0, 1, 16'hFFFF));   // r1 = 0000FFFF
    load(0,  1, itype(6'h0D, 0, 2, 16'h0001));   // r2 = 1
    load(0,  2, rtype(1, 2, 3, 6'h21));          // r3 = r1 + r2
    load(0,  3, rtype(0, 2, 4, 6'h23));          // r4 = 0 - 1
    load(0,  4, rtype(4, 2, 5, 6'h21));          // r5 = wraps to 0
    load(0,  5, itype(6'h0D, 0, 6, 16'h0010));   // r6 = 16
    load(0,  6, itype(6'h2B, 6, 1, 16'h0004));   // mem[20] = r1
    load(0,  7, itype(6'h23, 6, 7, 16'hFFFC));   // r7 = mem[12]
    load(0,  8, itype(6'h23, 6, 8, 16'h0004));   // r8 = mem[20]
    load(0,  9, itype(6'h0D, 0, 0, 16'h1234));   // r0 target
    load(0, 10, rtype(1, 1, 0, 6'h21));          // r0 target
    load(0, 11, itype(6'h3F, 1, 9, 16'h5555));   // unknown opcode
    load(0, 12, rtype(1, 1, 9, 6'h00));          // unknown function
    load(0, 13, itype(6'h04, 1, 2, 16'h0005));   // not taken
    load(0, 14, itype(6'h04, 5, 0, 16'h0002));   // taken to 68
    load(0, 15, itype(6'h0D, 0, 10, 16'h0BAD));
    load(0, 16, itype(6'h0D, 0, 10, 16'h0BAD));
    load(0, 17, itype(6'h0D, 0, 11, 16'h0007));  // r11 = 7
    load(0, 18, itype(6'h04, 11, 11, 16'h0001)); // taken to 80
    load(0, 19, itype(6'h0D, 0, 10, 16'h0BAD));
    load(0, 20, itype(6'h04, 0, 0, 16'hFFFF));   // self loop
    load(1,  3, 32'hCAFEF00D);
    load_en_i = 1'b0;

    // R1: held in reset
    dbg_raddr_i = 5'd3;
    #1;
    check("R1 pc in reset", pc_o, 32'd0);
    check("R1 reg in reset", dbg_rdata_o, 32'd0);

    push("R1 first fetch", 0);
    push("R4 ori zero-ext", 4, 1, 1, 32'h0000FFFF);
    push("R10 next-cycle visible", 8, 1, 2, 32'h1);
    push("R2 addu", 12, 1, 3, 32'h00010000);
    push("R3 subu wrap", 16, 1, 4, 32'hFFFFFFFF);
    push("R2 addu wrap", 20, 1, 5, 32'h0);
    push("R4 ori", 24, 1, 6, 32'd16);
    push("R6 store step", 28);
    push("R5 lw negative offset", 32, 1, 7, 32'hCAFEF00D);
    push("R6 lw after sw", 36, 1, 8, 32'h0000FFFF);
    push("R8 ori to r0", 40, 1, 0, 32'h0);
    push("R8 addu to r0", 44, 1, 0, 32'h0);
    push("R9 unknown opcode", 48, 1, 9, 32'h0);
    push("R9 unknown function", 52, 1, 9, 32'h0);
    push("R7 beq not taken", 56, 1, 2, 32'h1);
    push("R7 beq taken forward", 68, 1, 10, 32'h0);
    push("R10 r11 written", 72, 1, 11, 32'd7);
    push("R7 beq equal self", 80, 1, 10, 32'h0);
    push("R7 beq negative offset", 80);
    push("R7 loop holds", 80, 1, 8, 32'h0000FFFF);

    rst_ni = 1'b1;
    run = 1'b1;
    wait (done);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule